// File: doc/BRIEF.md
# Serially Configured Open-Drain Port Controller

This block is the pin-control part of a tuner control chip. A serial front end, which is not part of this block, collects a control word and presents it on a parallel bus with a one-cycle load strobe. The block keeps the control word in a register and drives four dedicated open-drain output pins and two pins that can be set as inputs or outputs. The pad ring receives a pull-low request for every pin and a drive enable for each dual-use pin.

The pin encoding is open-drain. A control bit of 0 releases the pin and a control bit of 1 pulls it low. Each dual-use pin has its own direction bit. When a dual-use pin is set as an input, its level passes through a two-flop synchronizer and is then captured in a read-back register for the serial link to return. When the time-base enable is set, the first dedicated pin carries an 8 Hz square wave divided down from the crystal clock, and its data bit is ignored. The crystal frequency is a parameter, so a 4.5 MHz or a 7.2 MHz reference gives an exact divider.

Top module: `port_ctl`

## Requirements
- R1: While reset is asserted and after it is released, `out_pull_low`, `io_drive_en`, `io_pull_low` and `rd_io_lvl` are all 0. Both dual-use pins are inputs and the time base is off.
- R2: On the clock edge where `cfg_load` is 1, `cfg_out[k]` is registered. From then on `out_pull_low[k]` is 1 (pin pulled low) when the bit is 1 and 0 (pin released) when the bit is 0. Pin 0 follows this rule only while the time base is off.
- R3: While `cfg_load` is 0, changes on the `cfg_*` inputs have no effect on any output.
- R4: While the registered time-base enable is 1, `out_pull_low[0]` follows the time base and ignores `cfg_out[0]`. Bits 1 to 3 still follow their data bits.
- R5: With HALF = XTAL_HZ/16 clock cycles, the time base starts released on the load edge that enables it. It stays released for HALF cycles, then pulls low for HALF cycles, and repeats. The duty cycle is 50%.
- R6: A load that clears the time-base enable returns `out_pull_low[0]` to `cfg_out[0]` right away. The next enable starts again from the released phase.
- R7: For dual-use pin i, a registered direction bit of 1 (output) gives `io_drive_en[i]`=1 and `io_pull_low[i]` equal to its value bit. A direction bit of 0 (input) gives 0 on both.
- R8: For a dual-use pin set as input, `rd_io_lvl[i]` shows the pin level three clock edges after `io_pin_lvl[i]` changes, with high read as 1 and low read as 0. A pin set as output reads 0.
- R9: All fields of one load (data bits, time-base enable, directions, values) take effect on the outputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-derived clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load strobe for the control word |
| cfg_out | input | 4 | Dedicated pin data bits, 1 = pull low |
| cfg_tb_en | input | 1 | Time-base enable for dedicated pin 0 |
| cfg_io_dir | input | 2 | Dual-use pin direction, 1 = output |
| cfg_io_val | input | 2 | Dual-use pin data bits, 1 = pull low |
| io_pin_lvl | input | 2 | Level seen on the dual-use pads |
| out_pull_low | output | 4 | Pull-low request for the dedicated pads |
| io_drive_en | output | 2 | Output enable for the dual-use pads |
| io_pull_low | output | 2 | Pull-low request for the dual-use pads |
| rd_io_lvl | output | 2 | Synchronized read-back of input pin levels |

## Verification
The dedicated outputs are loaded with alternating and all-ones patterns, so a swapped or inverted bit shows up. The same patterns are also driven without the strobe, to show that nothing moves unless a load occurs. The time base is enabled while data bit 0 is 1, which separates the override from the data path. It is then sampled on both sides of each half-period boundary to fix the divider length and the starting phase. Pin levels are changed and read back both two and three edges later, which pins down the synchronizer depth, and output-configured pins are checked to read 0.

// File: rtl/port_ctl_pkg.sv
package port_ctl_pkg;
    localparam int OUT_W = 4;
    localparam int IO_W  = 2;

    typedef struct packed {
        logic [OUT_W-1:0] out_low;
        logic             tb_en;
        logic [IO_W-1:0]  io_dir;
        logic [IO_W-1:0]  io_val;
    } cfg_t;
endpackage

// File: rtl/pc_timebase.sv
module pc_timebase #(
    parameter int XTAL_HZ = 4_500_000,
    parameter int TB_HZ   = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic phase
);
    localparam int HALF = XTAL_HZ / (2 * TB_HZ);
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ph;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d.cnt = '0;
            st_d.ph  = 1'b0;
        end else if (st_q.cnt == CW'(HALF - 1)) begin
            st_d.cnt = '0;
            st_d.ph  = ~st_q.ph;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign phase = st_q.ph;
endmodule

// File: rtl/pc_sync.sv
module pc_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.s2;
endmodule

// File: rtl/port_ctl.sv
module port_ctl
    import port_ctl_pkg::*;
#(
    parameter int XTAL_HZ = 4_500_000,
    parameter int TB_HZ   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic [OUT_W-1:0] cfg_out,
    input  logic             cfg_tb_en,
    input  logic [IO_W-1:0]  cfg_io_dir,
    input  logic [IO_W-1:0]  cfg_io_val,
    input  logic [IO_W-1:0]  io_pin_lvl,
    output logic [OUT_W-1:0] out_pull_low,
    output logic [IO_W-1:0]  io_drive_en,
    output logic [IO_W-1:0]  io_pull_low,
    output logic [IO_W-1:0]  rd_io_lvl
);
    typedef struct packed {
        cfg_t            cfg;
        logic [IO_W-1:0] rd;
    } st_t;

    st_t             st_d, st_q;
    cfg_t            cfg_new;
    logic [IO_W-1:0] lvl_s;
    logic            tb_on;
    logic            tb_phase;

    pc_sync #(.W(IO_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (io_pin_lvl),
        .q     (lvl_s)
    );

    pc_timebase #(.XTAL_HZ(XTAL_HZ), .TB_HZ(TB_HZ)) u_tb (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (tb_on),
        .phase (tb_phase)
    );

    always_comb begin
        cfg_new.out_low = cfg_out;
        cfg_new.tb_en   = cfg_tb_en;
        cfg_new.io_dir  = cfg_io_dir;
        cfg_new.io_val  = cfg_io_val;
    end

    always_comb begin
        st_d = st_q;
        if (cfg_load) st_d.cfg = cfg_new;
        for (int i = 0; i < IO_W; i++) begin
            st_d.rd[i] = st_q.cfg.io_dir[i] ? 1'b0 : lvl_s[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tb_on     = st_q.cfg.tb_en;
    assign rd_io_lvl = st_q.rd;

    for (genvar k = 0; k < OUT_W; k++) begin : g_out
        if (k == 0) begin : g_tb
            assign out_pull_low[k] = tb_on ? tb_phase : st_q.cfg.out_low[k];
        end else begin : g_plain
            assign out_pull_low[k] = st_q.cfg.out_low[k];
        end
    end

    for (genvar i = 0; i < IO_W; i++) begin : g_io
        assign io_drive_en[i] = st_q.cfg.io_dir[i];
        assign io_pull_low[i] = st_q.cfg.io_dir[i] & st_q.cfg.io_val[i];
    end
endmodule

// File: rtl/port_ctl_chk.sv
module port_ctl_chk
    import port_ctl_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_load,
    input logic             tb_on,
    input logic [OUT_W-1:0] out_pull_low,
    input logic [IO_W-1:0]  io_drive_en,
    input logic [IO_W-1:0]  io_pull_low,
    input logic [IO_W-1:0]  rd_io_lvl
);
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_load) |-> ($stable(io_drive_en) && $stable(io_pull_low)
                              && $stable(out_pull_low[OUT_W-1:1])));

    assert_pin0_still_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cfg_load) && !tb_on && !$past(tb_on)) |-> $stable(out_pull_low[0]));

    for (genvar i = 0; i < IO_W; i++) begin : g_io_chk
        assert_low_needs_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
            io_pull_low[i] |-> io_drive_en[i]);

        assert_out_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $past(io_drive_en[i]) |-> !rd_io_lvl[i]);
    end
endmodule

bind port_ctl port_ctl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_load     (cfg_load),
    .tb_on        (tb_on),
    .out_pull_low (out_pull_low),
    .io_drive_en  (io_drive_en),
    .io_pull_low  (io_pull_low),
    .rd_io_lvl    (rd_io_lvl)
);

// File: tb/port_ctl_tb.sv
module port_ctl_tb;
    localparam int XTAL = 320;
    localparam int HALF = XTAL / 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_load = 1'b0;
    logic [3:0] cfg_out = '0;
    logic       cfg_tb_en = 1'b0;
    logic [1:0] cfg_io_dir = '0;
    logic [1:0] cfg_io_val = '0;
    logic [1:0] io_pin_lvl = '0;
    logic [3:0] out_pull_low;
    logic [1:0] io_drive_en;
    logic [1:0] io_pull_low;
    logic [1:0] rd_io_lvl;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    port_ctl #(.XTAL_HZ(XTAL), .TB_HZ(8)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_load     (cfg_load),
        .cfg_out      (cfg_out),
        .cfg_tb_en    (cfg_tb_en),
        .cfg_io_dir   (cfg_io_dir),
        .cfg_io_val   (cfg_io_val),
        .io_pin_lvl   (io_pin_lvl),
        .out_pull_low (out_pull_low),
        .io_drive_en  (io_drive_en),
        .io_pull_low  (io_pull_low),
        .rd_io_lvl    (rd_io_lvl)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    task automatic load(input logic [3:0] o, input logic tb, input logic [1:0] dir,
                        input logic [1:0] val);
        @(negedge clk);
        cfg_out = o; cfg_tb_en = tb; cfg_io_dir = dir; cfg_io_val = val;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 reset outs", {4'h0, out_pull_low}, 8'h00);
        chk("R1 reset io", {2'b0, io_drive_en, io_pull_low, rd_io_lvl}, 8'h00);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 after release", {out_pull_low, io_drive_en, io_pull_low}, 8'h00);
    endtask

    task automatic t_outputs();
        load(4'b0101, 1'b0, 2'b00, 2'b00);
        chk("R2 pattern 0101", {4'h0, out_pull_low}, 8'h05);
        load(4'b1010, 1'b0, 2'b00, 2'b00);
        chk("R2 pattern 1010", {4'h0, out_pull_low}, 8'h0A);
        load(4'b1111, 1'b0, 2'b00, 2'b00);
        chk("R2 pattern 1111", {4'h0, out_pull_low}, 8'h0F);
    endtask

    task automatic t_hold();
        @(negedge clk);
        cfg_out = 4'b0000; cfg_io_dir = 2'b11; cfg_io_val = 2'b11; cfg_tb_en = 1'b1;
        repeat (3) @(negedge clk);
        chk("R3 no load outs", {4'h0, out_pull_low}, 8'h0F);
        chk("R3 no load io", {4'h0, io_drive_en, io_pull_low}, 8'h00);
    endtask

    task automatic t_timebase();
        load(4'b0011, 1'b1, 2'b00, 2'b00);
        chk("R4 data bit 0 overridden", {4'h0, out_pull_low}, 8'h02);
        repeat (HALF - 1) @(negedge clk);
        chk("R5 still released", {7'h0, out_pull_low[0]}, 8'h00);
        @(negedge clk);
        chk("R5 low after half", {7'h0, out_pull_low[0]}, 8'h01);
        chk("R4 other bits keep data", {5'h0, out_pull_low[3:1]}, 8'h01);
        repeat (HALF - 1) @(negedge clk);
        chk("R5 low at end of half", {7'h0, out_pull_low[0]}, 8'h01);
        @(negedge clk);
        chk("R5 released after period", {7'h0, out_pull_low[0]}, 8'h00);
        repeat (HALF + 3) @(negedge clk);
        load(4'b0001, 1'b0, 2'b00, 2'b00);
        chk("R6 data bit back", {4'h0, out_pull_low}, 8'h01);
        load(4'b0000, 1'b1, 2'b00, 2'b00);
        repeat (HALF - 1) @(negedge clk);
        chk("R6 restart released", {7'h0, out_pull_low[0]}, 8'h00);
        @(negedge clk);
        chk("R6 restart low", {7'h0, out_pull_low[0]}, 8'h01);
        load(4'b0000, 1'b0, 2'b00, 2'b00);
    endtask

    task automatic t_io_dir();
        load(4'b0000, 1'b0, 2'b01, 2'b11);
        chk("R7 dir 01 val 11", {4'h0, io_drive_en, io_pull_low}, 8'h05);
        load(4'b0000, 1'b0, 2'b11, 2'b10);
        chk("R7 dir 11 val 10", {4'h0, io_drive_en, io_pull_low}, 8'h0E);
    endtask

    task automatic t_readback();
        load(4'b0000, 1'b0, 2'b00, 2'b00);
        @(negedge clk);
        io_pin_lvl = 2'b00;
        repeat (3) @(negedge clk);
        chk("R8 both low", {6'h0, rd_io_lvl}, 8'h00);
        io_pin_lvl = 2'b10;
        repeat (2) @(negedge clk);
        chk("R8 not yet after two edges", {6'h0, rd_io_lvl}, 8'h00);
        @(negedge clk);
        chk("R8 level after three edges", {6'h0, rd_io_lvl}, 8'h02);
        io_pin_lvl = 2'b11;
        load(4'b0000, 1'b0, 2'b01, 2'b00);
        repeat (3) @(negedge clk);
        chk("R8 output pin reads 0", {6'h0, rd_io_lvl}, 8'h02);
    endtask

    task automatic t_same_cycle();
        load(4'b0000, 1'b0, 2'b00, 2'b00);
        @(negedge clk);
        cfg_out = 4'b1001; cfg_tb_en = 1'b0; cfg_io_dir = 2'b10; cfg_io_val = 2'b10;
        cfg_load = 1'b1;
        chk("R9 before edge", {out_pull_low, io_drive_en, io_pull_low}, 8'h00);
        @(negedge clk);
        cfg_load = 1'b0;
        chk("R9 all fields together", {out_pull_low, io_drive_en, io_pull_low}, 8'h9A);
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        t_reset();
        t_outputs();
        t_hold();
        t_timebase();
        t_io_dir();
        t_readback();
        t_same_cycle();
        finish_run();
    end
endmodule